// File: doc/BRIEF.md
# MSI vector capture controller

This block sits behind the inbound write path of a host bridge and turns message-signalled interrupt writes into pending bits. Every inbound write is compared against a programmable target address. On a match, the 32-bit data word names a vector. The vector's bank is the data value divided by 32, and its bit is the remainder. If software has enabled that vector, its pending bit is set.

Software reaches the block through a simple register port. Reads return data one cycle after the request. The port holds:
- the target address;
- a global enable;
- a controller-level event latch;
- for each bank, an enable word and a write-one-to-clear status word, with the banks laid out at a fixed 12-byte stride.

A single level interrupt goes to the host processor while the global enable is set and any enabled vector is pending.

The usual service sequence has four steps. Software reads each bank's status and dispatches the vectors it finds. It then writes the same value back to clear them. Finally it reads the event latch and writes it back to acknowledge it.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, irq is low and reg_rvalid is low.
- R2: An inbound write is taken as an interrupt only when msi_wr_addr equals the target register (byte offset 0x000, full 32 bits). Any other address leaves all state unchanged.
- R3: The vector number is the full data word. It selects bank data/32 and bit data%32. A value of NUM_BANKS*32 or more (256 with defaults) is dropped.
- R4: Bank b has its enable word at offset 0x100 + 12*b and its status word at 0x100 + 12*b + 4. Offset 0x100 + 12*b + 8, and every other unmapped offset, reads zero.
- R5: A pending bit is set only when the vector's enable bit is 1 in the cycle the write arrives. Writes to disabled vectors are dropped.
- R6: Writing a status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: When an inbound set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R8: irq is high exactly when global enable (bit 0 of offset 0x004) is 1 and some bank has a bit that is both pending and enabled. Clearing an enable bit masks its pending bit without clearing it.
- R9: The event latch (bit 0 of offset 0x008) is set by any accepted inbound interrupt while global enable is 1. Writing 1 to it clears it, so reading it and writing the value back acknowledges it. A capture in the same cycle as the clear wins.
- R10: reg_rvalid pulses exactly one cycle after reg_rd_en, and reg_rdata then holds the register value from before any write in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msi_wr_valid | input | 1 | Inbound write strobe |
| msi_wr_addr | input | 32 | Inbound write address, low word |
| msi_wr_data | input | 32 | Inbound write data (vector number) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd_en |
| irq | output | 1 | Aggregated level interrupt |

## Verification
Two pairs of operations can land in the same cycle. An inbound interrupt can meet a software write-one-to-clear of the same status bit. An accepted capture can meet a write-back acknowledge of the event latch. The bench forces both collisions by driving the inbound write and the register write in one cycle. It then checks that the bit or the latch reads back as set, with irq still high. Randomised traffic then mixes captures, enable changes and clears over many cycles, and a behavioural reference model is compared with irq and read data on every clock.

// File: rtl/msi_cap_pkg.sv
// Shared constants for the MSI vector capture controller.
// Assumes a 12-bit byte-offset register space and 32 vectors per bank.
package msi_cap_pkg;
    localparam int BANK_W      = 32;
    localparam int BANK_STRIDE = 12;
    localparam logic [11:0] OFS_TARGET    = 12'h000;
    localparam logic [11:0] OFS_CTRL      = 12'h004;
    localparam logic [11:0] OFS_LEVEL     = 12'h008;
    localparam logic [11:0] OFS_BANK_BASE = 12'h100;
    localparam logic [11:0] OFS_STATUS    = 12'h004;
    typedef logic [BANK_W-1:0] word_t;
endpackage

// File: rtl/msi_decoder.sv
// Inbound write decoder: matches the target address and turns the data
// word into a one-hot set request across all banks.
// Assumes the data word is the vector number; out-of-range values are dropped.
module msi_decoder
    import msi_cap_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid,
    input  logic [31:0]                   wr_addr,
    input  logic [31:0]                   wr_data,
    input  logic [31:0]                   target,
    output logic [NUM_BANKS-1:0][BANK_W-1:0] hit
);
    localparam logic [31:0] VEC_LIMIT = 32'(NUM_BANKS * BANK_W);

    logic        match;
    logic [31:0] bank_sel;

    // Address match plus range check on the vector number.
    always_comb begin
        match    = wr_valid && (wr_addr == target) && (wr_data < VEC_LIMIT);
        bank_sel = wr_data >> 5;
    end

    // One set-request word per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        always_comb begin
            hit[b] = '0;
            if (match && bank_sel == 32'(b))
                hit[b] = word_t'(1) << wr_data[4:0];
        end
    end

    // R3
    onehot_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/msi_bank.sv
// One bank of 32 vectors: enable word and write-one-to-clear status word.
// Assumes set requests are already decoded; an inbound set beats a clear.
module msi_bank
    import msi_cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t set_req,
    input  logic  en_we,
    input  logic  st_we,
    input  word_t wdata,
    output word_t enable_q,
    output word_t status_q,
    output logic  pend,
    output logic  accept
);
    word_t set_eff;
    word_t clr_mask;

    // Gate set requests by enable and form the clear mask.
    always_comb begin
        set_eff  = set_req & enable_q;
        clr_mask = st_we ? wdata : '0;
        pend     = |(status_q & enable_q);
        accept   = |set_eff;
    end

    // Enable word register.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable_q <= '0;
        else if (en_we) enable_q <= wdata;
    end

    // Status word: clear written ones, then merge new sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | set_eff;
    end

    // R5
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0));
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_req & enable_q)) |=> ((status_q & $past(set_req & enable_q)) == $past(set_req & enable_q)));
    // R6
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> ((status_q & $past(wdata) & ~$past(set_req & enable_q)) == '0));
endmodule

// File: rtl/msi_capture_ctrl.sv
// MSI vector capture controller top: control registers, bank array,
// registered read mux and the aggregated interrupt.
// Assumes one register access per cycle and single-cycle inbound writes.
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int REG_AW    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_wr_valid,
    input  logic [31:0]       msi_wr_addr,
    input  logic [31:0]       msi_wr_data,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              irq
);
    logic [31:0] target_q;
    logic        gen_en_q;
    logic        level_q;

    logic [NUM_BANKS-1:0][BANK_W-1:0] hit;
    word_t                 en_w  [NUM_BANKS];
    word_t                 st_w  [NUM_BANKS];
    logic [NUM_BANKS-1:0]  pend_v;
    logic [NUM_BANKS-1:0]  acc_v;
    logic                  accept_any;
    logic [31:0]           rd_mux;

    msi_decoder #(.NUM_BANKS(NUM_BANKS)) i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (msi_wr_valid),
        .wr_addr  (msi_wr_addr),
        .wr_data  (msi_wr_data),
        .target   (target_q),
        .hit      (hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [REG_AW-1:0] EN_OFS = REG_AW'(OFS_BANK_BASE + b * BANK_STRIDE);
        localparam logic [REG_AW-1:0] ST_OFS = REG_AW'(OFS_BANK_BASE + b * BANK_STRIDE + OFS_STATUS);
        msi_bank i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_req  (hit[b]),
            .en_we    (reg_wr_en && reg_addr == EN_OFS),
            .st_we    (reg_wr_en && reg_addr == ST_OFS),
            .wdata    (reg_wdata),
            .enable_q (en_w[b]),
            .status_q (st_w[b]),
            .pend     (pend_v[b]),
            .accept   (acc_v[b])
        );
    end

    // Aggregate pending and accepted events across banks.
    always_comb begin
        accept_any = |acc_v;
        irq        = gen_en_q && (|pend_v);
    end

    // Target address and global enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            gen_en_q <= 1'b0;
        end else if (reg_wr_en) begin
            if (reg_addr == REG_AW'(OFS_TARGET)) target_q <= reg_wdata;
            if (reg_addr == REG_AW'(OFS_CTRL))   gen_en_q <= reg_wdata[0];
        end
    end

    // Event latch: write-one-to-clear, capture wins.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else level_q <= (level_q && !(reg_wr_en && reg_addr == REG_AW'(OFS_LEVEL) && reg_wdata[0]))
                        || (accept_any && gen_en_q);
    end

    // Read multiplexer over control and bank registers.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == REG_AW'(OFS_TARGET)) rd_mux = target_q;
        if (reg_addr == REG_AW'(OFS_CTRL))   rd_mux = {31'b0, gen_en_q};
        if (reg_addr == REG_AW'(OFS_LEVEL))  rd_mux = {31'b0, level_q};
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == REG_AW'(OFS_BANK_BASE + b * BANK_STRIDE))              rd_mux = en_w[b];
            if (reg_addr == REG_AW'(OFS_BANK_BASE + b * BANK_STRIDE + OFS_STATUS)) rd_mux = st_w[b];
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd_en;
            if (reg_rd_en) reg_rdata <= rd_mux;
        end
    end

    // R10
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> reg_rvalid);
    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> !reg_rvalid);
    // R9
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_any && gen_en_q) |=> level_q);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_v && gen_en_q) |-> irq);
endmodule

// File: tb/test_msi_capture_ctrl.sv
`timescale 1ns/1ps
module test_msi_capture_ctrl;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_wr_valid = 1'b0;
    logic [31:0] msi_wr_addr = '0;
    logic [31:0] msi_wr_data = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        irq;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    msi_capture_ctrl i_msi_capture_ctrl (
        .clk(clk), .rst_n(rst_n),
        .msi_wr_valid(msi_wr_valid), .msi_wr_addr(msi_wr_addr), .msi_wr_data(msi_wr_data),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq)
    );

    // Behavioural reference state
    logic [31:0] m_en [NB];
    logic [31:0] m_st [NB];
    logic [31:0] m_tgt = '0;
    logic        m_gen = 1'b0;
    logic        m_lat = 1'b0;
    logic        m_rvalid = 1'b0;
    logic [31:0] m_rdata = '0;

    function automatic logic [31:0] mread(int a);
        if (a == 0) return m_tgt;
        if (a == 4) return {31'b0, m_gen};
        if (a == 8) return {31'b0, m_lat};
        for (int b = 0; b < NB; b++) begin
            if (a == 256 + 12 * b) return m_en[b];
            if (a == 260 + 12 * b) return m_st[b];
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin m_en[b] = '0; m_st[b] = '0; end
            m_tgt = '0; m_gen = 0; m_lat = 0; m_rvalid = 0; m_rdata = '0;
        end else begin
            int  vb, vk, a;
            bit  acc, gen_old;
            acc = 0; vb = 0; vk = 0;
            gen_old = m_gen;
            m_rvalid = reg_rd_en;
            if (reg_rd_en) m_rdata = mread(int'(reg_addr));
            if (msi_wr_valid && msi_wr_addr == m_tgt && msi_wr_data < 32'd256) begin
                vb = int'(msi_wr_data) / 32;
                vk = int'(msi_wr_data) % 32;
                acc = m_en[vb][vk];
            end
            if (reg_wr_en) begin
                a = int'(reg_addr);
                if (a == 0) m_tgt = reg_wdata;
                if (a == 4) m_gen = reg_wdata[0];
                if (a == 8 && reg_wdata[0]) m_lat = 0;
                for (int b = 0; b < NB; b++) begin
                    if (a == 256 + 12 * b) m_en[b] = reg_wdata;
                    if (a == 260 + 12 * b) m_st[b] = m_st[b] & ~reg_wdata;
                end
            end
            if (acc) begin
                m_st[vb][vk] = 1'b1;
                if (gen_old) m_lat = 1'b1;
            end
        end
    end

    function automatic bit m_irq();
        bit any = 0;
        for (int b = 0; b < NB; b++) if ((m_st[b] & m_en[b]) != 0) any = 1;
        return m_gen && any;
    endfunction

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        checks++;
        if (irq !== m_irq()) begin
            errors++;
            $display("FAIL %s/R8: irq actual %0b expected %0b at %0t", cur_req, irq, m_irq(), $time);
        end
        checks++;
        if (reg_rvalid !== m_rvalid) begin
            errors++;
            $display("FAIL %s/R10: rvalid actual %0b expected %0b at %0t", cur_req, reg_rvalid, m_rvalid, $time);
        end
        if (m_rvalid) begin
            checks++;
            if (reg_rdata !== m_rdata) begin
                errors++;
                $display("FAIL %s: rdata actual %h expected %h at %0t", cur_req, reg_rdata, m_rdata, $time);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        msi_wr_valid = 0; reg_wr_en = 0; reg_rd_en = 0;
    endtask
    task automatic wr(int a, logic [31:0] d);
        reg_wr_en = 1; reg_addr = 12'(a); reg_wdata = d; step();
    endtask
    task automatic rd(int a);
        reg_rd_en = 1; reg_addr = 12'(a); step();
    endtask
    task automatic msi(logic [31:0] a, logic [31:0] d);
        msi_wr_valid = 1; msi_wr_addr = a; msi_wr_data = d; step();
    endtask

    localparam logic [31:0] TGT = 32'hFEE0_1000;

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) step();
        rd(0);
        #2 rst_n = 1;
        @(negedge clk);
        rd(0); rd(4); rd(8); rd(256); rd(260); rd(256 + 12 * 7 + 4);
        step();

        cur_req = "R2";
        wr(0, TGT); wr(4, 1); wr(256, 32'h0000_0008);
        msi(TGT ^ 32'h4, 3); rd(260);
        msi(TGT, 3); rd(260); rd(8);

        cur_req = "R5";
        msi(TGT, 40); rd(272);
        msi(TGT, 2); rd(260);

        cur_req = "R3";
        wr(268, 32'h0000_0100); wr(256 + 12 * 7, 32'h8000_0000);
        msi(TGT, 40); msi(TGT, 255); msi(TGT, 256); msi(TGT, 32'h0001_0028);
        rd(272); rd(256 + 12 * 7 + 4);

        cur_req = "R4";
        rd(264); rd(256 + 12 * 7 + 8); rd(252); rd(512); rd(12); rd(268);

        cur_req = "R6";
        wr(256, 32'hFFFF_FFFF);
        msi(TGT, 0); msi(TGT, 1); msi(TGT, 5); rd(260);
        wr(260, 32'h0000_0002); rd(260);
        wr(260, 32'h0000_0000); rd(260);

        cur_req = "R7";
        msi_wr_valid = 1; msi_wr_addr = TGT; msi_wr_data = 5;
        wr(260, 32'h0000_0020); rd(260);

        cur_req = "R8";
        wr(4, 0); rd(4); step();
        wr(4, 1); step();
        wr(256, 32'h0); rd(260); step();
        wr(256, 32'hFFFF_FFFF);
        wr(260, 32'hFFFF_FFFF); wr(272, 32'hFFFF_FFFF); wr(256 + 12 * 7 + 4, 32'hFFFF_FFFF);
        step();

        cur_req = "R9";
        rd(8); wr(8, 32'h1); rd(8);
        msi(TGT, 7); rd(8);
        msi_wr_valid = 1; msi_wr_addr = TGT; msi_wr_data = 9;
        wr(8, 32'h1); rd(8);
        wr(4, 0); wr(8, 1); msi(TGT, 11); rd(8); wr(4, 1);

        cur_req = "R10";
        reg_rd_en = 1; reg_wr_en = 1; reg_addr = 12'd0; reg_wdata = 32'h1234_5678; step();
        rd(0);
        reg_rd_en = 1; reg_wr_en = 1; reg_addr = 12'd260; reg_wdata = 32'hFFFF_FFFF; step();
        rd(260);
        wr(0, TGT);

        cur_req = "R7";
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5) begin
                msi_wr_valid = 1;
                msi_wr_addr  = ($urandom_range(0, 7) == 0) ? 32'($urandom) : TGT;
                msi_wr_data  = 32'($urandom_range(0, 300));
            end
            if (op >= 3) begin
                int b;
                b = $urandom_range(0, NB - 1);
                case ($urandom_range(0, 5))
                    0: begin reg_wr_en = 1; reg_addr = 12'(256 + 12 * b); reg_wdata = 32'($urandom); end
                    1, 2: begin reg_wr_en = 1; reg_addr = 12'(260 + 12 * b); reg_wdata = 32'($urandom); end
                    3: begin reg_wr_en = 1; reg_addr = 12'd8; reg_wdata = 32'($urandom_range(0, 1)); end
                    4: begin reg_wr_en = 1; reg_addr = 12'd4; reg_wdata = 32'($urandom_range(0, 3) != 0); end
                    default: ;
                endcase
                reg_rd_en = 1;
                if (!reg_wr_en) reg_addr = 12'(256 + 12 * b + 4 * $urandom_range(0, 2));
            end
            step();
        end
        step(); step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule